// File: doc/BRIEF.md
# Reciprocal Square Root Operand Prefixer

This block sits in front of an iterative reciprocal square root unit that works on IEEE-754 binary32 values. Each accepted operand is classified. Special inputs (NaN, negative nonzero, infinite and zero) get fixed replacement values and a cleared proceed bit, so the downstream iteration is skipped. For ordinary positive inputs the block forwards the operand with proceed set. When the operand's biased exponent field is small, the block first multiplies the operand by 2^64 so that the iteration stays in the normal range. It then tags the result with an adjust code that the back end uses to undo the scaling.

The block has one register stage. An operand presented with `valid_i` in one cycle yields the fixed-up operand, the initial result word, the adjust code, the proceed bit and a one-cycle invalid-exception pulse, all on the next cycle and qualified by `valid_o`. Seed lookup, the Newton steps and the final rounding are handled elsewhere.

Top module: `isq_prefix`

## Requirements
- R1: A NaN input (exponent field 0xFF, mantissa nonzero, either sign) drives both `operand_o` and `result_o` to 0xFFFFFFFF, with `proceed_o` 0 and `adjust_o` 0.
- R2: For a NaN input, `invalid_o` pulses exactly when mantissa bit 22 of the input is 0 (signalling NaN). A quiet NaN (bit 22 set) raises no invalid.
- R3: A negative nonzero input that is not a NaN drives both outputs to 0xFFFFFFFF and pulses `invalid_o`. This covers negative normals, negative subnormals and negative infinity. Proceed is 0 and adjust is 0.
- R4: Positive infinity drives both `operand_o` and `result_o` to 0x7F800000, with no invalid, proceed 0 and adjust 0.
- R5: Positive or negative zero passes through to `operand_o` unchanged, with `result_o` = 0x3F800000 (+1.0), proceed 0, adjust 0 and no invalid.
- R6: A positive normal input whose biased exponent field exceeds 24 passes through unchanged, with `result_o` 0, `adjust_o` 0 and `proceed_o` 1.
- R7: A positive normal input whose biased exponent field is in 1..24 leaves as the same value times 2^64. Its exponent field is raised by 64, its sign and mantissa are unchanged, `adjust_o` is 0xE0, `result_o` is 0 and `proceed_o` is 1.
- R8: A positive subnormal input is multiplied by 2^64 and renormalized exactly. If its highest set mantissa bit is p, the output exponent field is p+42 and the output mantissa is the input mantissa shifted left by 23-p with the leading one dropped. Adjust is 0xE0 and proceed is 1.
- R9: The outputs for an operand appear in the cycle after `valid_i`, with `valid_o` high for that one cycle. `invalid_o` is never high without `valid_o`.
- R10: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand strobe |
| operand_i | input | 32 | binary32 operand |
| valid_o | output | 1 | Outputs valid, one cycle after `valid_i` |
| operand_o | output | 32 | Fixed-up or pre-scaled operand |
| result_o | output | 32 | Initial result word |
| adjust_o | output | 8 | Scaling tag: 0xE0 when scaled, else 0 |
| proceed_o | output | 1 | 1 when the iteration must run |
| invalid_o | output | 1 | Invalid-operation pulse |

## Verification
The assertions check several relations on every cycle. An invalid pulse always comes with a valid output and an all-ones operand. Proceed always comes with a zero result word. A nonzero adjust code is always 0xE0 on a proceeding operand, with an exponent inside the range that scaling can produce. Every strobe is followed by a valid output. Only the bench's scenarios can show the exact replacement values per class, the quiet/signalling split, the exact renormalization of subnormals and the threshold edge at exponent field 24 versus 25. The bench compares these against its own reference model on directed and random operands.

// File: rtl/isq_pkg.sv
package isq_pkg;
  localparam int unsigned EXP_W    = 8;
  localparam int unsigned MAN_W    = 23;
  localparam int unsigned WORD_W   = 1 + EXP_W + MAN_W;
  localparam int unsigned SCALE_SH = 64;
  localparam int unsigned THRESH   = 24;
  localparam int unsigned ADJ_W    = 8;
  localparam logic [ADJ_W-1:0] ADJ_SCALED = 8'hE0;

  typedef enum logic [2:0] {
    CL_NORM,
    CL_ZERO,
    CL_PINF,
    CL_NAN,
    CL_NEG
  } op_class_e;

  typedef struct packed {
    logic [WORD_W-1:0] operand;
    logic [WORD_W-1:0] result;
    logic [ADJ_W-1:0]  adjust;
    logic              proceed;
    logic              invalid;
  } fixup_t;
endpackage

// File: rtl/isq_classify.sv
module isq_classify
  import isq_pkg::*;
#(
  parameter int unsigned EW = EXP_W,
  parameter int unsigned MW = MAN_W,
  localparam int unsigned W = 1 + EW + MW
) (
  input  logic [W-1:0] op_i,
  output op_class_e    cls_o,
  output logic         signalling_o
);
  logic          sgn;
  logic [EW-1:0] ex;
  logic [MW-1:0] mn;
  assign {sgn, ex, mn} = op_i;

  always_comb begin
    if (&ex && |mn)            cls_o = CL_NAN;
    else if (sgn && (|ex || |mn)) cls_o = CL_NEG;  // -0 falls through to zero
    else if (&ex)              cls_o = CL_PINF;
    else if (!(|ex) && !(|mn)) cls_o = CL_ZERO;
    else                       cls_o = CL_NORM;
  end

  assign signalling_o = ~mn[MW-1];
endmodule

// File: rtl/isq_scale.sv
module isq_scale
  import isq_pkg::*;
#(
  parameter int unsigned EW = EXP_W,
  parameter int unsigned MW = MAN_W,
  parameter int unsigned SH = SCALE_SH,
  localparam int unsigned W  = 1 + EW + MW,
  localparam int unsigned LW = $clog2(MW + 1),
  localparam int SUB_BASE    = 1 - int'(MW) + int'(SH)
) (
  input  logic [W-1:0] op_i,
  output logic [W-1:0] scaled_o
);
  logic          sgn;
  logic [EW-1:0] ex;
  logic [MW-1:0] mn;
  assign {sgn, ex, mn} = op_i;

  logic [LW-1:0] lead;
  always_comb begin
    lead = '0;
    for (int i = 0; i < int'(MW); i++)
      if (mn[i]) lead = LW'(i);
  end

  logic [MW:0]   norm_mn;
  logic [EW-1:0] sub_ex;
  assign norm_mn = {1'b0, mn} << (LW'(MW) - lead);
  assign sub_ex  = EW'(int'(lead) + SUB_BASE);

  // subnormal: exact renormalization; normal: exponent bump only
  always_comb begin
    if (ex == '0) scaled_o = {sgn, sub_ex, norm_mn[MW-1:0]};
    else          scaled_o = {sgn, ex + EW'(SH), mn};
  end
endmodule

// File: rtl/isq_select.sv
module isq_select
  import isq_pkg::*;
#(
  parameter int unsigned EW = EXP_W,
  parameter int unsigned MW = MAN_W,
  parameter int unsigned TH = THRESH,
  localparam int unsigned W = 1 + EW + MW,
  localparam int BIAS       = (1 << (EW - 1)) - 1
) (
  input  logic [W-1:0] op_i,
  input  logic [W-1:0] scaled_i,
  input  op_class_e    cls_i,
  input  logic         signalling_i,
  output fixup_t       fix_o
);
  localparam logic [W-1:0] NAN_WORD = '1;
  localparam logic [W-1:0] PINF     = {1'b0, {EW{1'b1}}, {MW{1'b0}}};
  localparam logic [W-1:0] ONE      = {1'b0, EW'(BIAS), {MW{1'b0}}};

  logic small_ex;
  assign small_ex = op_i[W-2 -: EW] <= EW'(TH);

  always_comb begin
    fix_o = '0;
    unique case (cls_i)
      CL_NAN: begin
        fix_o.operand = NAN_WORD;
        fix_o.result  = NAN_WORD;
        fix_o.invalid = signalling_i;
      end
      CL_NEG: begin
        fix_o.operand = NAN_WORD;
        fix_o.result  = NAN_WORD;
        fix_o.invalid = 1'b1;
      end
      CL_PINF: begin
        fix_o.operand = PINF;
        fix_o.result  = PINF;
      end
      CL_ZERO: begin
        fix_o.operand = op_i;
        fix_o.result  = ONE;
      end
      default: begin
        fix_o.proceed = 1'b1;
        fix_o.operand = small_ex ? scaled_i : op_i;
        fix_o.adjust  = small_ex ? ADJ_SCALED : '0;
      end
    endcase
  end
endmodule

// File: rtl/isq_prefix.sv
module isq_prefix
  import isq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] operand_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] operand_o,
  output logic [WORD_W-1:0] result_o,
  output logic [ADJ_W-1:0]  adjust_o,
  output logic              proceed_o,
  output logic              invalid_o
);
  op_class_e         cls;
  logic              signalling;
  logic [WORD_W-1:0] scaled;
  fixup_t            fix, fix_q;
  logic              vld_q;

  isq_classify #(.EW(EXP_W), .MW(MAN_W)) i_classify (
    .op_i(operand_i), .cls_o(cls), .signalling_o(signalling)
  );

  isq_scale #(.EW(EXP_W), .MW(MAN_W), .SH(SCALE_SH)) i_scale (
    .op_i(operand_i), .scaled_o(scaled)
  );

  isq_select #(.EW(EXP_W), .MW(MAN_W), .TH(THRESH)) i_select (
    .op_i(operand_i), .scaled_i(scaled), .cls_i(cls),
    .signalling_i(signalling), .fix_o(fix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      fix_q <= '0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) fix_q <= fix;
      else         fix_q.invalid <= 1'b0;
    end
  end

  assign valid_o   = vld_q;
  assign operand_o = fix_q.operand;
  assign result_o  = fix_q.result;
  assign adjust_o  = fix_q.adjust;
  assign proceed_o = fix_q.proceed;
  assign invalid_o = fix_q.invalid;

  // R9
  invalid_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> valid_o);
  // R9
  strobe_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R3
  invalid_nan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> (operand_o == '1 && result_o == '1 && !proceed_o));
  // R6
  proceed_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && proceed_o) |-> result_o == '0);
  // R7
  adjust_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && adjust_o != '0) |-> (proceed_o && adjust_o == ADJ_SCALED));
  // R8
  scaled_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && adjust_o == ADJ_SCALED) |->
      (operand_o[WORD_W-2 -: EXP_W] >= EXP_W'(SCALE_SH + 1 - MAN_W) &&
       operand_o[WORD_W-2 -: EXP_W] <= EXP_W'(THRESH + SCALE_SH)));
endmodule

// File: tb/test_isq_prefix.sv
module test_isq_prefix;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] operand_i = '0;
  logic        valid_o, proceed_o, invalid_o;
  logic [31:0] operand_o, result_o;
  logic [7:0]  adjust_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  isq_prefix i_isq_prefix (
    .clk_i, .rst_ni, .valid_i, .operand_i, .valid_o,
    .operand_o, .result_o, .adjust_o, .proceed_o, .invalid_o
  );

  typedef struct packed {
    logic [31:0] op;
    logic [31:0] res;
    logic [7:0]  adj;
    logic        go;
    logic        inv;
  } exp_t;

  function automatic exp_t ref_model(input logic [31:0] x);
    exp_t e;
    logic [7:0]  ex = x[30:23];
    logic [22:0] mn = x[22:0];
    e = '0;
    if (ex == 8'hFF && mn != 0) begin
      e.op = '1; e.res = '1; e.inv = ~mn[22];                // R1 R2
    end else if (x[31] && (ex != 0 || mn != 0)) begin
      e.op = '1; e.res = '1; e.inv = 1'b1;                   // R3
    end else if (ex == 8'hFF) begin
      e.op = 32'h7F800000; e.res = 32'h7F800000;             // R4
    end else if (ex == 0 && mn == 0) begin
      e.op = x; e.res = 32'h3F800000;                        // R5
    end else begin
      e.go = 1'b1;
      if (ex > 24) e.op = x;                                 // R6
      else begin
        e.adj = 8'hE0;
        if (ex != 0) e.op = {x[31], ex + 8'd64, mn};         // R7
        else begin                                           // R8
          int p = 0;
          for (int i = 0; i < 23; i++) if (mn[i]) p = i;
          e.op = {x[31], 8'(p + 42), 23'(mn << (23 - p))};
        end
      end
    end
    return e;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  task automatic apply(input logic [31:0] x, input string tag);
    exp_t e = ref_model(x);
    @(negedge clk_i);
    operand_i = x; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk({tag, " R9 valid"}, {31'd0, valid_o}, 32'd1);
    chk({tag, " operand"}, operand_o, e.op);
    chk({tag, " result"}, result_o, e.res);
    chk({tag, " adjust"}, {24'd0, adjust_o}, {24'd0, e.adj});
    chk({tag, " proceed"}, {31'd0, proceed_o}, {31'd0, e.go});
    chk({tag, " invalid"}, {31'd0, invalid_o}, {31'd0, e.inv});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    // R10
    chk("R10 reset outputs", operand_o | result_o | {24'd0, adjust_o} |
        {29'd0, valid_o, proceed_o, invalid_o}, 32'd0);
    rst_ni = 1'b1;
    apply(32'h7FC00000, "R1 R2 quiet nan");
    apply(32'h7F800001, "R1 R2 signalling nan");
    apply(32'hFFA00000, "R1 R2 neg signalling nan");
    apply(32'hBF800000, "R3 neg normal");
    apply(32'h80000001, "R3 neg subnormal");
    apply(32'hFF800000, "R3 neg inf");
    apply(32'h7F800000, "R4 pos inf");
    apply(32'h00000000, "R5 pos zero");
    apply(32'h80000000, "R5 neg zero");
    apply(32'h0C800000, "R6 exp 25");
    apply(32'h3F800000, "R6 one");
    apply(32'h7F7FFFFF, "R6 max normal");
    apply(32'h0C7FFFFF, "R7 exp 24");
    apply(32'h00800000, "R7 exp 1");
    apply(32'h00000001, "R8 min subnormal");
    apply(32'h007FFFFF, "R8 max subnormal");
    apply(32'h00400000, "R8 top bit subnormal");
    // R9: invalid and valid last one cycle
    @(negedge clk_i);
    chk("R9 pulse end", {30'd0, valid_o, invalid_o}, 32'd0);
    for (int n = 0; n < 400; n++) begin
      logic [31:0] x = $urandom;
      case ($urandom % 6)
        0: x[30:23] = 8'($urandom % 26);
        1: x[30:23] = 8'd0;
        2: x[30:23] = 8'hFF;
        3: x[31] = 1'b0;
        default: ;
      endcase
      apply(x, "R1..R8 random");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule